// File: doc/BRIEF.md
# Supply-Fail and Manual Reset Pulse Generator

This block turns a digitized supply-good level, two push-button style manual reset inputs of opposite polarity, and a watchdog expiry strobe into a pair of complementary reset levels. Supply loss forces reset as soon as the loss has outlasted a short glitch filter. When the supply comes back, reset is held for a fixed timeout before release. Manual inputs are edge-sensed: each active edge launches one timeout-length reset pulse, no matter how long the input stays asserted.

A separate "reset active" flag is offered to neighbouring logic. It covers the reset outputs and also any interval in which a manual input is still held at its active level, so a memory controller can refuse access and a watchdog can stay frozen for that whole time. Any new trigger that arrives during a running timeout restarts the count from its full length.

Top module: `power_reset_gen`

## Requirements
- R1: While `arstN` is low, and after its release for as long as the supply has not been recognized as good, `rstOutHigh` is 1, `rstOutLowN` is 0 and `rstActive` is 1.
- R2: After `supplyOk` rises and stays high, the supply is recognized as good at the (GLITCH_CYC+2)th clock edge; reset then stays active for TIMEOUT_CYC more cycles and releases at edge GLITCH_CYC+2+TIMEOUT_CYC.
- R3: When `supplyOk` is low for GLITCH_CYC consecutive samples, reset asserts at the (GLITCH_CYC+2)th edge after the fall, without any timeout wait.
- R4: A low pulse on `supplyOk` lasting fewer than GLITCH_CYC clock samples leaves all outputs unchanged.
- R5: A rising edge on `mrHighIn` (active level 1) makes reset active from the third clock edge after it for exactly TIMEOUT_CYC cycles; holding the input longer does not extend the pulse.
- R6: A falling edge on `mrLowNIn` (active level 0) behaves as in R5; its rising edge starts nothing.
- R7: `wdExpire` sampled high at a clock edge makes reset active from that edge for exactly TIMEOUT_CYC cycles.
- R8: A trigger arriving while a timeout runs reloads the full TIMEOUT_CYC count.
- R9: `rstActive` is 1 whenever reset is active, and also from the second clock edge after a manual input reaches its active level until the second edge after it leaves it.
- R10: `rstOutLowN` is always the inverse of `rstOutHigh`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arstN | input | 1 | Asynchronous active-low register reset |
| supplyOk | input | 1 | Digitized supply-good level, asynchronous |
| mrHighIn | input | 1 | Manual reset request, active high, asynchronous |
| mrLowNIn | input | 1 | Manual reset request, active low, asynchronous |
| wdExpire | input | 1 | Synchronous watchdog expiry strobe |
| rstOutHigh | output | 1 | Reset level, active high |
| rstOutLowN | output | 1 | Reset level, active low |
| rstActive | output | 1 | Reset or held manual request, for blocking access |

## Verification
The supply input is driven with a power-up rise, a dip one sample shorter than the filter and a dip exactly as long as it, which separates a filter that is too short or too long from a correct one and shows that loss asserts reset without a timeout. Each manual input is held far longer than the timeout, which tells edge sensing apart from level sensing and shows the flag outlasting the outputs. Single and repeated watchdog strobes show the exact pulse length and tell a reloading counter from one that ignores retriggers.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  typedef struct packed {
    logic supplyLow;
    logic loadTimer;
  } rstStrobe_t;
endpackage

// File: rtl/rstgen_ctrl.sv
module rstgen_ctrl
  import rstgen_pkg::*;
#(
  parameter int GLITCH_CYC = 4
) (
  input  logic       clk,
  input  logic       arstN,
  input  logic       supplyOk,
  input  logic       mrHighIn,
  input  logic       mrLowNIn,
  input  logic       wdExpire,
  output rstStrobe_t strobe,
  output logic       manualHeld
);
  localparam int GW = $clog2(GLITCH_CYC + 1);
  localparam logic [GW-1:0] GLITCH_LAST = GW'(GLITCH_CYC - 1);
  localparam int NSYNC = 3;
  // bit order: {supply, manual high, manual low-n}; reset to inactive levels
  localparam logic [NSYNC-1:0] SYNC_INIT = 3'b001;

  logic [NSYNC-1:0] syncStage [2];
  logic [NSYNC-1:0] syncPrev;
  logic             supGood;
  logic [GW-1:0]    glitchCnt;

  genvar gs;
  generate
    for (gs = 0; gs < 2; gs++) begin : g_sync
      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN) syncStage[gs] <= SYNC_INIT;
        else if (gs == 0) syncStage[gs] <= {supplyOk, mrHighIn, mrLowNIn};
        else syncStage[gs] <= syncStage[gs-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) syncPrev <= SYNC_INIT;
    else        syncPrev <= syncStage[1];
  end

  // symmetric glitch filter on the synchronized supply level
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      supGood   <= 1'b0;
      glitchCnt <= '0;
    end else if (syncStage[1][2] != supGood) begin
      if (glitchCnt == GLITCH_LAST) begin
        supGood   <= syncStage[1][2];
        glitchCnt <= '0;
      end else begin
        glitchCnt <= glitchCnt + 1'b1;
      end
    end else begin
      glitchCnt <= '0;
    end
  end

  logic riseHigh, fallLow;
  assign riseHigh = syncStage[1][1] & ~syncPrev[1];
  assign fallLow  = ~syncStage[1][0] & syncPrev[0];

  assign strobe.supplyLow = ~supGood;
  assign strobe.loadTimer = riseHigh | fallLow | wdExpire;
  assign manualHeld       = syncStage[1][1] | ~syncStage[1][0];
endmodule

// File: rtl/rstgen_dp.sv
module rstgen_dp
  import rstgen_pkg::*;
#(
  parameter int TIMEOUT_CYC = 200
) (
  input  logic       clk,
  input  logic       arstN,
  input  rstStrobe_t strobe,
  output logic       timerBusy
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] TIMER_FULL = TW'(TIMEOUT_CYC);

  logic [TW-1:0] timer;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)                                    timer <= TIMER_FULL;
    else if (strobe.supplyLow || strobe.loadTimer) timer <= TIMER_FULL;
    else if (timer != '0)                          timer <= timer - 1'b1;
  end

  assign timerBusy = (timer != '0);
endmodule

// File: rtl/power_reset_gen.sv
module power_reset_gen
  import rstgen_pkg::*;
#(
  parameter int TIMEOUT_CYC = 200,
  parameter int GLITCH_CYC  = 4
) (
  input  logic clk,
  input  logic arstN,
  input  logic supplyOk,
  input  logic mrHighIn,
  input  logic mrLowNIn,
  input  logic wdExpire,
  output logic rstOutHigh,
  output logic rstOutLowN,
  output logic rstActive
);
  rstStrobe_t strobe;
  logic       manualHeld;
  logic       timerBusy;

  rstgen_ctrl #(.GLITCH_CYC(GLITCH_CYC)) u_ctrl (
    .clk(clk), .arstN(arstN), .supplyOk(supplyOk), .mrHighIn(mrHighIn),
    .mrLowNIn(mrLowNIn), .wdExpire(wdExpire), .strobe(strobe),
    .manualHeld(manualHeld)
  );

  rstgen_dp #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_dp (
    .clk(clk), .arstN(arstN), .strobe(strobe), .timerBusy(timerBusy)
  );

  assign rstOutHigh = strobe.supplyLow | timerBusy;
  assign rstOutLowN = ~rstOutHigh;
  assign rstActive  = rstOutHigh | manualHeld;
endmodule

// File: rtl/rstgen_checker.sv
module rstgen_checker #(
  parameter int GLITCH_CYC = 4
) (
  input logic clk,
  input logic arstN,
  input logic supplyOk,
  input logic mrHighIn,
  input logic wdExpire,
  input logic rstOutHigh,
  input logic rstActive
);
  localparam int LW = $clog2(GLITCH_CYC + 3) + 1;
  localparam logic [LW-1:0] LOW_LIMIT = LW'(GLITCH_CYC + 2);

  logic [LW-1:0] lowRun;
  logic [1:0]    sinceRst;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      lowRun   <= '0;
      sinceRst <= '0;
    end else begin
      if (supplyOk)              lowRun <= '0;
      else if (lowRun != LOW_LIMIT) lowRun <= lowRun + 1'b1;
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 1'b1;
    end
  end

  AST_SUPPLY_LOSS: assert property (@(posedge clk) disable iff (!arstN)
    (lowRun == LOW_LIMIT) |-> rstOutHigh); // R3

  AST_WD_PULSE: assert property (@(posedge clk) disable iff (!arstN)
    wdExpire |=> rstOutHigh); // R7

  AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (!arstN)
    (sinceRst == 2'd3 && mrHighIn && !$past(mrHighIn)) |=> ##2 rstOutHigh); // R5

  AST_HELD_ACTIVE: assert property (@(posedge clk) disable iff (!arstN)
    (sinceRst == 2'd3 && $past(mrHighIn, 2)) |-> rstActive); // R9
endmodule

bind power_reset_gen rstgen_checker #(.GLITCH_CYC(GLITCH_CYC)) u_chk (
  .clk(clk), .arstN(arstN), .supplyOk(supplyOk), .mrHighIn(mrHighIn),
  .wdExpire(wdExpire), .rstOutHigh(rstOutHigh), .rstActive(rstActive)
);

// File: tb/test_power_reset_gen.sv
module test_power_reset_gen;
  localparam int CLK_PERIOD = 10;
  localparam int T = 20;
  localparam int G = 4;

  logic clk = 1'b0;
  logic arstN = 1'b0, supplyOk = 1'b0, mrHighIn = 1'b0, mrLowNIn = 1'b1, wdExpire = 1'b0;
  logic rstOutHigh, rstOutLowN, rstActive;

  power_reset_gen #(.TIMEOUT_CYC(T), .GLITCH_CYC(G)) i_power_reset_gen (
    .clk(clk), .arstN(arstN), .supplyOk(supplyOk), .mrHighIn(mrHighIn),
    .mrLowNIn(mrLowNIn), .wdExpire(wdExpire), .rstOutHigh(rstOutHigh),
    .rstOutLowN(rstOutLowN), .rstActive(rstActive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { string tag; bit high; bit act; } expItem_t;
  expItem_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic expectNow(string tag, bit h, bit a);
    expItem_t it;
    it.tag = tag; it.high = h; it.act = a;
    q.push_back(it);
  endtask

  task automatic gap(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares outputs against queued expectations
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      expItem_t it;
      it = q.pop_front();
      checks++;
      if (rstOutHigh !== it.high || rstActive !== it.act) begin
        errors++;
        $display("FAIL %s: high=%b act=%b expected high=%b act=%b",
                 it.tag, rstOutHigh, rstActive, it.high, it.act);
      end
      checks++;
      if (rstOutLowN !== !it.high) begin
        errors++;
        $display("FAIL R10 (%s): lowN=%b expected %b", it.tag, rstOutLowN, !it.high);
      end
    end
  end

  initial begin
    gap(3);
    expectNow("R1 in reset", 1, 1);
    arstN = 1'b1;
    gap(3);
    expectNow("R1 supply not yet good", 1, 1);
    // power-up
    supplyOk = 1'b1;
    gap(5 + T); expectNow("R2 still held", 1, 1);
    gap(1);     expectNow("R2 released", 0, 0);
    // short dip
    gap(2);
    supplyOk = 1'b0;
    gap(G - 1); supplyOk = 1'b1;
    gap(3); expectNow("R4 short dip ignored", 0, 0);
    gap(3); expectNow("R4 short dip ignored later", 0, 0);
    // real loss
    gap(2);
    supplyOk = 1'b0;
    gap(G); supplyOk = 1'b1;
    gap(1); expectNow("R3 before filter ends", 0, 0);
    gap(1); expectNow("R3 loss asserts", 1, 1);
    gap(3 + T); expectNow("R2 recovery held", 1, 1);
    gap(1);     expectNow("R2 recovery released", 0, 0);
    // manual high
    gap(2);
    mrHighIn = 1'b1;
    gap(2);     expectNow("R9 held before pulse", 0, 1);
    gap(1);     expectNow("R5 pulse starts", 1, 1);
    gap(T - 1); expectNow("R5 pulse last cycle", 1, 1);
    gap(1);     expectNow("R5 no extension while held", 0, 1);
    mrHighIn = 1'b0;
    gap(2);     expectNow("R9 release", 0, 0);
    // manual low
    gap(2);
    mrLowNIn = 1'b0;
    gap(3);     expectNow("R6 pulse starts", 1, 1);
    gap(T - 1); expectNow("R6 pulse last cycle", 1, 1);
    gap(1);     expectNow("R6 no extension while held", 0, 1);
    mrLowNIn = 1'b1;
    gap(2);     expectNow("R9 low release", 0, 0);
    gap(3);     expectNow("R6 rising edge starts nothing", 0, 0);
    // watchdog
    gap(2);
    wdExpire = 1'b1;
    gap(1); wdExpire = 1'b0;
    expectNow("R7 pulse starts", 1, 1);
    gap(T - 1); expectNow("R7 pulse last cycle", 1, 1);
    gap(1);     expectNow("R7 pulse ends", 0, 0);
    // retrigger
    gap(2);
    wdExpire = 1'b1;
    gap(1); wdExpire = 1'b0;
    gap(9); wdExpire = 1'b1;
    gap(1); wdExpire = 1'b0;
    gap(T - 1); expectNow("R8 restarted count", 1, 1);
    gap(1);     expectNow("R8 restarted count ends", 0, 0);
    gap(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule